// File: doc/BRIEF.md
# EEPROM Byte and Burst Access Controller

This block lets a host reach an external byte-wide EEPROM through a small register file. The host loads an EEPROM address and, for writes, a data byte. It then sets a request bit in the control register. The controller runs one byte transaction on the EEPROM port. When that transaction finishes, the controller clears the request bit itself. After a read, the fetched byte is in the data register.

The block also offers a burst mode that copies EEPROM content into on-chip memory. Each memory entry takes three EEPROM bytes in sequence: the low address byte, the high address byte, and then the data byte. The on-chip target address joins the nine bits of a base register with the lower fifteen bits of that 16-bit EEPROM-supplied address, so the top bit of the high byte is dropped. A length register gives the number of entries in a burst.

The EEPROM side is a request/acknowledge byte port. The memory side is a one-cycle write strobe with address and data. Bursts fetch from a running pointer. The pointer starts at EEPROM address 0 after reset, and each access moves it to the location after the last byte touched.

Top module: `ee_access_ctrl`

## Requirements
- R1: Writing the control register (offset 0) with bit 1 set reads one byte from the EEPROM at the address register (offset 1) into the data register (offset 2). Bit 1 reads back as 1 until the read has completed, then returns to 0.
- R2: Writing the control register with only bit 0 set writes the data register byte to the EEPROM at the address register. `ee_we` is high during that transaction, and bit 0 returns to 0 when the write completes.
- R3: `ee_req` stays high until `ee_ack` is seen. `ee_addr`, `ee_we` and `ee_wdata` stay stable while `ee_req` waits for the acknowledge.
- R4: Writing 1 to bit 0 of the burst register (offset 5) starts a burst. That bit reads 1 while the burst runs and returns to 0 by itself when the burst ends.
- R5: A burst started after reset, with no earlier single access, fetches from EEPROM address 0 upward.
- R6: A burst started after an earlier access fetches from the EEPROM address one past the last byte that access touched.
- R7: Each memory write address is {base[8:0], hi[6:0], lo[7:0]}. Here base is the base register (offset 3), and lo and hi are the first and second bytes of the entry. Bit 7 of hi is ignored.
- R8: A burst with length register (offset 4) value N gives exactly N memory writes. Each write uses three consecutive EEPROM bytes in the order low address, high address, data. `mem_we` is never high on two consecutive cycles.
- R9: Control register bit 2 reads 1 while a single access or a burst is in progress. Every register write made while busy is ignored, including new requests.
- R10: After reset, all readable registers are 0, `ee_req` is low and `mem_we` is low.
- R11: A burst with length 0 ends on its own, performs no memory write and fetches nothing, so the fetch pointer does not move.
- R12: If control bits 1 and 0 are both set in one write, only the read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data of the selected register |
| ee_req | output | 1 | EEPROM byte request |
| ee_we | output | 1 | Request is a write |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_ack | input | 1 | EEPROM acknowledge, ends the request |
| ee_rdata | input | 8 | EEPROM read byte, valid with ee_ack |
| mem_we | output | 1 | On-chip memory write strobe |
| mem_addr | output | 24 | On-chip memory target address |
| mem_data | output | 8 | On-chip memory write byte |

## Verification
The assertions check on every cycle that the EEPROM request is held and kept stable until it is acknowledged. They also check that requests appear only while the block is busy, that memory writes are spaced apart, and that each write carries the base register in its upper bits. Some behaviours are visible only across whole scenarios, so the bench covers them. These are the fetch pointer carrying over between accesses, the low fifteen address bits and data assembled from EEPROM bytes, read-over-write priority, empty bursts, and writes that are dropped while busy. A scoreboard predicts each memory write from an EEPROM image model.

// File: rtl/ee_access_pkg.sv
package ee_access_pkg;

    localparam int EE_AW  = 16;
    localparam int BYTE_W = 8;
    localparam int REG_DW = 16;
    localparam int REG_AW = 3;

    localparam int CB_WR   = 0;
    localparam int CB_RD   = 1;
    localparam int CB_BUSY = 2;

    typedef enum logic [REG_AW-1:0] {
        RS_CTRL  = 3'd0,
        RS_ADDR  = 3'd1,
        RS_DATA  = 3'd2,
        RS_BASE  = 3'd3,
        RS_LEN   = 3'd4,
        RS_BURST = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_SINGLE,
        CS_BURST
    } ctl_state_e;

    typedef struct packed {
        logic              go;
        logic              we;
        logic [EE_AW-1:0]  addr;
        logic [BYTE_W-1:0] data;
    } byte_req_t;

    function automatic logic [REG_DW-1:0] ctrl_view(input logic busy,
                                                    input logic rd,
                                                    input logic wr);
        logic [REG_DW-1:0] v;
        v = '0;
        v[CB_BUSY] = busy;
        v[CB_RD]   = rd;
        v[CB_WR]   = wr;
        return v;
    endfunction

endpackage

// File: rtl/ee_byte_port.sv
module ee_byte_port
    import ee_access_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  byte_req_t         req_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic              we_o,
    output logic [EE_AW-1:0]  addr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              done_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_o   <= 1'b0;
            we_o    <= 1'b0;
            addr_o  <= '0;
            wdata_o <= '0;
        end else if (req_i.go && !req_o) begin
            req_o   <= 1'b1;
            we_o    <= req_i.we;
            addr_o  <= req_i.addr;
            wdata_o <= req_i.data;
        end else if (req_o && ack_i) begin
            req_o <= 1'b0;
        end
    end

    assign done_o = req_o & ack_i;

endmodule

// File: rtl/ee_burst_pack.sv
module ee_burst_pack
    import ee_access_pkg::*;
#(
    parameter int BASE_W = 9,
    localparam int TGT_W = BASE_W + EE_AW - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              byte_done_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BASE_W-1:0] base_i,
    output logic              pair_done_o,
    output logic              mem_we_o,
    output logic [TGT_W-1:0]  mem_addr_o,
    output logic [BYTE_W-1:0] mem_data_o
);

    logic [1:0]        phase_q;
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;
    logic [EE_AW-1:0]  src_addr;

    assign src_addr    = {hi_q, lo_q};
    assign pair_done_o = byte_done_i && (phase_q == 2'd2);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            phase_q    <= 2'd0;
            lo_q       <= '0;
            hi_q       <= '0;
            mem_we_o   <= 1'b0;
            mem_addr_o <= '0;
            mem_data_o <= '0;
        end else begin
            mem_we_o <= 1'b0;
            if (byte_done_i) begin
                case (phase_q)
                    2'd0: begin
                        lo_q    <= byte_i;
                        phase_q <= 2'd1;
                    end
                    2'd1: begin
                        hi_q    <= byte_i;
                        phase_q <= 2'd2;
                    end
                    default: begin
                        mem_we_o   <= 1'b1;
                        mem_addr_o <= {base_i, src_addr[EE_AW-2:0]};
                        mem_data_o <= byte_i;
                        phase_q    <= 2'd0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/ee_access_ctrl.sv
module ee_access_ctrl
    import ee_access_pkg::*;
#(
    parameter int BASE_W = 9,
    parameter int LEN_W  = 16,
    localparam int TGT_W = BASE_W + EE_AW - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EE_AW-1:0]  ee_addr,
    output logic [BYTE_W-1:0] ee_wdata,
    input  logic              ee_ack,
    input  logic [BYTE_W-1:0] ee_rdata,
    output logic              mem_we,
    output logic [TGT_W-1:0]  mem_addr,
    output logic [BYTE_W-1:0] mem_data
);

    ctl_state_e        state_q;
    logic [EE_AW-1:0]  addr_q;
    logic [EE_AW-1:0]  ptr_q;
    logic [BYTE_W-1:0] data_q;
    logic [BASE_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  remain_q;
    logic              rd_pend_q;
    logic              wr_pend_q;

    logic      busy;
    logic      accept;
    logic      single_go;
    logic      burst_go;
    logic      burst_fetch;
    logic      port_done;
    logic      pair_done;
    byte_req_t breq;

    assign busy   = (state_q != CS_IDLE);
    assign accept = reg_wr && !busy;

    always_comb begin
        single_go   = accept && (reg_addr == RS_CTRL) &&
                      (reg_wdata[CB_RD] || reg_wdata[CB_WR]);
        burst_go    = accept && (reg_addr == RS_BURST) && reg_wdata[0];
        burst_fetch = (state_q == CS_BURST) && !ee_req && (remain_q != '0);
        breq.go     = single_go || burst_fetch;
        breq.we     = single_go && !reg_wdata[CB_RD];
        breq.addr   = single_go ? addr_q : ptr_q;
        breq.data   = data_q;
    end

    ee_byte_port u_port (
        .clk     (clk),
        .rst     (rst),
        .req_i   (breq),
        .ack_i   (ee_ack),
        .req_o   (ee_req),
        .we_o    (ee_we),
        .addr_o  (ee_addr),
        .wdata_o (ee_wdata),
        .done_o  (port_done)
    );

    ee_burst_pack #(.BASE_W(BASE_W)) u_pack (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (burst_go),
        .byte_done_i (port_done && (state_q == CS_BURST)),
        .byte_i      (ee_rdata),
        .base_i      (base_q),
        .pair_done_o (pair_done),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_data_o  (mem_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= CS_IDLE;
            addr_q    <= '0;
            ptr_q     <= '0;
            data_q    <= '0;
            base_q    <= '0;
            len_q     <= '0;
            remain_q  <= '0;
            rd_pend_q <= 1'b0;
            wr_pend_q <= 1'b0;
        end else begin
            if (accept) begin
                case (reg_addr)
                    RS_ADDR: addr_q <= reg_wdata[EE_AW-1:0];
                    RS_DATA: data_q <= reg_wdata[BYTE_W-1:0];
                    RS_BASE: base_q <= reg_wdata[BASE_W-1:0];
                    RS_LEN:  len_q  <= reg_wdata[LEN_W-1:0];
                    default: ;
                endcase
            end
            if (single_go) begin
                state_q   <= CS_SINGLE;
                rd_pend_q <= reg_wdata[CB_RD];
                wr_pend_q <= !reg_wdata[CB_RD];
                ptr_q     <= addr_q + 1'b1;
            end
            if (burst_go) begin
                state_q  <= CS_BURST;
                remain_q <= len_q;
            end
            if (burst_fetch) begin
                ptr_q <= ptr_q + 1'b1;
            end
            case (state_q)
                CS_SINGLE: begin
                    if (port_done) begin
                        if (rd_pend_q) data_q <= ee_rdata;
                        rd_pend_q <= 1'b0;
                        wr_pend_q <= 1'b0;
                        state_q   <= CS_IDLE;
                    end
                end
                CS_BURST: begin
                    if (pair_done) remain_q <= remain_q - 1'b1;
                    if ((remain_q == '0) && !ee_req) state_q <= CS_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            RS_CTRL:  reg_rdata = ctrl_view(busy, rd_pend_q, wr_pend_q);
            RS_ADDR:  reg_rdata = REG_DW'(addr_q);
            RS_DATA:  reg_rdata = REG_DW'(data_q);
            RS_BASE:  reg_rdata = REG_DW'(base_q);
            RS_LEN:   reg_rdata = REG_DW'(len_q);
            RS_BURST: reg_rdata = REG_DW'(state_q == CS_BURST);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ee_access_chk.sv
module ee_access_chk
    import ee_access_pkg::*;
#(
    parameter int BASE_W = 9,
    localparam int TGT_W = BASE_W + EE_AW - 1
) (
    input logic              clk,
    input logic              rst,
    input logic              ee_req,
    input logic              ee_ack,
    input logic              ee_we,
    input logic [EE_AW-1:0]  ee_addr,
    input logic [BYTE_W-1:0] ee_wdata,
    input logic              mem_we,
    input logic [TGT_W-1:0]  mem_addr,
    input logic [BASE_W-1:0] base_q,
    input ctl_state_e        state_q
);

    // R3: a pending request persists until acknowledged
    a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
        ee_req && !ee_ack |=> ee_req);

    // R3: request fields do not move while waiting
    a_r3_fields_stable: assert property (@(posedge clk) disable iff (rst)
        ee_req && !ee_ack |=> $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata));

    // R9: EEPROM traffic only while the controller reports busy
    a_r9_req_when_busy: assert property (@(posedge clk) disable iff (rst)
        ee_req |-> state_q != CS_IDLE);

    // R7: upper target bits come from the base register
    a_r7_base_upper: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr[TGT_W-1:TGT_W-BASE_W] == base_q);

    // R8: memory writes are single-cycle strobes
    a_r8_write_spacing: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

endmodule

bind ee_access_ctrl ee_access_chk #(.BASE_W(BASE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ee_req   (ee_req),
    .ee_ack   (ee_ack),
    .ee_we    (ee_we),
    .ee_addr  (ee_addr),
    .ee_wdata (ee_wdata),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .base_q   (base_q),
    .state_q  (state_q)
);

// File: tb/ee_access_ctrl_tb.sv
module ee_access_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        ee_req, ee_we;
    logic [15:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic        ee_ack;
    logic [7:0]  ee_rdata;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_data;

    int checks = 0;
    int errors = 0;
    int pops = 0;
    int wcount;
    logic [15:0] wlog_addr;
    logic [7:0]  wlog_data;
    logic [15:0] exp_ptr = 16'd0;
    logic [8:0]  exp_base = 9'd0;
    logic [23:0] q_addr[$];
    logic [7:0]  q_data[$];

    always #2.5 clk = ~clk;

    ee_access_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ee_req(ee_req),
        .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_ack(ee_ack),
        .ee_rdata(ee_rdata), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    function automatic logic [7:0] img(input logic [15:0] a);
        logic [15:0] t;
        t = a * 16'd37 + 16'h0091;
        return t[7:0] ^ t[15:8];
    endfunction

    // EEPROM model: image ROM plus a write logger
    assign ee_rdata = img(ee_addr);
    always @(posedge clk) begin
        if (rst) begin
            ee_ack    <= 1'b0;
            wcount    <= 0;
            wlog_addr <= '0;
            wlog_data <= '0;
        end else begin
            ee_ack <= ee_req & ~ee_ack;
            if (ee_req && ee_ack && ee_we) begin
                wcount    <= wcount + 1;
                wlog_addr <= ee_addr;
                wlog_data <= ee_wdata;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            checks++;
            if (q_addr.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected write actual=%0h expected=none", mem_addr);
            end else begin
                logic [23:0] ea;
                logic [7:0]  ed;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                pops++;
                if (mem_addr !== ea || mem_data !== ed) begin
                    errors++;
                    $display("FAIL R7 write actual=%0h/%0h expected=%0h/%0h",
                             mem_addr, mem_data, ea, ed);
                end
            end
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 2000; i++) begin
            rd_reg(3'd0, v);
            if (!v[2]) return;
        end
        chk(1'b0, "R9 never idle", 1, 0);
    endtask

    task automatic push_burst(input int n);
        for (int k = 0; k < n; k++) begin
            logic [7:0] lo, hi, d;
            lo = img(exp_ptr);
            hi = img(exp_ptr + 16'd1);
            d  = img(exp_ptr + 16'd2);
            q_addr.push_back({exp_base, hi[6:0], lo});
            q_data.push_back(d);
            exp_ptr = exp_ptr + 16'd3;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        int p0, w0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R10 reset state
        rd_reg(3'd0, v); chk(v == 0, "R10 ctrl", v, 0);
        rd_reg(3'd1, v); chk(v == 0, "R10 addr", v, 0);
        rd_reg(3'd5, v); chk(v == 0, "R10 burst", v, 0);
        chk(!ee_req && !mem_we, "R10 outputs", {ee_req, mem_we}, 0);

        // R5 R7 R8 burst from reset, hi bit 7 dropped
        exp_base = 9'h155;
        wr_reg(3'd3, 16'h0155);
        wr_reg(3'd4, 16'd3);
        p0 = pops;
        push_burst(3);
        wr_reg(3'd5, 16'd1);
        rd_reg(3'd5, v); chk(v == 1, "R4 burst active", v, 1);
        wait_idle();
        rd_reg(3'd5, v); chk(v == 0, "R4 self clear", v, 0);
        chk(pops - p0 == 3, "R5 R8 write count", pops - p0, 3);

        // R1 single read, R9 busy visible
        wr_reg(3'd1, 16'h0120);
        wr_reg(3'd0, 16'h0002);
        rd_reg(3'd0, v); chk(v[2:1] == 2'b11, "R9 busy and R1 pending", v, 6);
        wait_idle();
        rd_reg(3'd0, v); chk(v == 0, "R1 bit clear", v, 0);
        rd_reg(3'd2, v); chk(v == 16'(img(16'h0120)), "R1 data", v, img(16'h0120));
        exp_ptr = 16'h0121;

        // R6 burst resumes after last access
        wr_reg(3'd4, 16'd2);
        p0 = pops;
        push_burst(2);
        wr_reg(3'd5, 16'd1);
        wait_idle();
        chk(pops - p0 == 2, "R6 write count", pops - p0, 2);

        // R2 single write
        wr_reg(3'd2, 16'h00C3);
        wr_reg(3'd1, 16'h0FFE);
        w0 = wcount;
        wr_reg(3'd0, 16'h0001);
        rd_reg(3'd0, v); chk(v[0] == 1'b1, "R2 pending", v, 5);
        wait_idle();
        rd_reg(3'd0, v); chk(v == 0, "R2 bit clear", v, 0);
        chk(wcount == w0 + 1 && wlog_addr == 16'h0FFE && wlog_data == 8'hC3,
            "R2 eeprom write", {wlog_addr, wlog_data}, 24'h0FFEC3);

        // R12 both bits: read wins
        wr_reg(3'd1, 16'h0040);
        w0 = wcount;
        wr_reg(3'd0, 16'h0003);
        wait_idle();
        chk(wcount == w0, "R12 no write", wcount, w0);
        rd_reg(3'd2, v); chk(v == 16'(img(16'h0040)), "R12 read data", v, img(16'h0040));
        exp_ptr = 16'h0041;

        // R11 empty burst, pointer unchanged
        wr_reg(3'd4, 16'd0);
        p0 = pops;
        wr_reg(3'd5, 16'd1);
        wait_idle();
        rd_reg(3'd5, v); chk(v == 0, "R11 burst clear", v, 0);
        chk(pops == p0, "R11 no writes", pops - p0, 0);
        wr_reg(3'd4, 16'd1);
        push_burst(1);
        wr_reg(3'd5, 16'd1);
        wait_idle();
        chk(pops - p0 == 1, "R11 pointer kept", pops - p0, 1);

        // R9 writes ignored while busy
        wr_reg(3'd4, 16'd2);
        push_burst(2);
        p0 = pops;
        w0 = wcount;
        wr_reg(3'd5, 16'd1);
        wr_reg(3'd1, 16'h0777);
        wr_reg(3'd4, 16'd9);
        wr_reg(3'd0, 16'h0001);
        wait_idle();
        rd_reg(3'd1, v); chk(v == 16'h0040, "R9 addr kept", v, 16'h0040);
        rd_reg(3'd4, v); chk(v == 16'd2, "R9 len kept", v, 2);
        chk(wcount == w0, "R9 request dropped", wcount, w0);
        chk(pops - p0 == 2, "R9 burst intact", pops - p0, 2);

        repeat (10) @(negedge clk);
        chk(q_addr.size() == 0, "R8 scoreboard empty", q_addr.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule